// File: doc/BRIEF.md
# SD Host Status and Interrupt Register

This block holds the 32-bit status word and the interrupt-enable word of an SD card host controller. Event strobes from the command, data and card-detect logic set sticky flags in the status word. Software clears a flag by writing a 1 to its position. The buffer-ready, buffer-empty, buffer-full and card-clock-running flags work differently. They are sampled copies of live level inputs and do not respond to writes. A two-bit field records the status code that came back with the most recent write-CRC failure.

A single interrupt line is raised when a flag that can interrupt is set and its enable bit is also set. The line is registered, so it follows the status word by one clock. The error flags (mask 0x2f) have no enable of their own. Software is expected to find them when it reads the status after a completion interrupt. A one-bit address selects which register the bus port reads or writes. Read data is combinational from the stored state.

Top module: `sdh_stat_irq`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no stimulus, both registers read 0 and `irq_o` is 0.
- R2: A 1 on `evt_i[n]` sets status bit n on the next clock edge, and the bit stays set. This applies to n in {31 card in, 30 card out, 25 underrun, 24 overflow, 14 SDIO, 13 command end, 12 write done, 11 read done, 5 response CRC, 3 read CRC, 2 write CRC, 1 response timeout, 0 read timeout}. Strobes on any other bit position have no effect.
- R3: A write with `bus_addr_i`=0 clears every sticky status bit that has a 1 in `bus_wdata_i`. Sticky bits that have a 0 in `bus_wdata_i` are not changed.
- R4: When a set strobe and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bits 6, 7, 8, 26, 27, 28 and 29 show `lvl_i[0]` through `lvl_i[6]` as sampled at the previous clock edge. Writes to the status register do not affect them.
- R6: Status bits [10:9] load `wcrc_code_i` in the cycle that `evt_i[2]` is set. They return to 0 when bit 2 is cleared by a write with no new strobe. Code 2 means the card sent no CRC token.
- R7: A write with `bus_addr_i`=1 stores `bus_wdata_i` into the enable register, keeping only bits 0–4 and 12–18. All other enable bits read 0.
- R8: `irq_o` is 1 one clock after any of the following pairs is 1 in the same cycle: (enable 0, status 11), (1, 12), (2, 13), (3, 6), (4, 7), (13, 14), (14, 30), (15, 31). Otherwise `irq_o` is 0.
- R9: The error bits (mask 0x2f) never raise `irq_o` on their own, even with every enable bit set.
- R10: `bus_rdata_o` shows the status word when `bus_addr_i`=0 and the enable word when `bus_addr_i`=1, in the same cycle that the address changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | One-cycle event strobes, indexed by status bit position |
| lvl_i | input | 7 | Live levels: write ready, read ready, clock running, X full, Y full, X empty, Y empty |
| wcrc_code_i | input | 2 | Write-CRC status code, taken together with `evt_i[2]` |
| bus_addr_i | input | 1 | Register select: 0 status, 1 enable |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data (write-1-clear for status) |
| bus_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets four corner cases:
- A clear and a set landing on the same bit in the same cycle. A design that lets the clear win loses an event.
- All-ones writes aimed at the level flags. A design that treats those flags as write-1-clear would show a ready flag dropping while the buffer is still ready.
- Raising only the error flags with every enable set. This exposes a design that mapped an error into the interrupt sum.
- Each enable/status pair on its own. This catches a swapped position, which would raise the line on the wrong source or one cycle early or late.

// File: rtl/sdh_stat_pkg.sv
package sdh_stat_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned NUM_LVL = 7;
  localparam int unsigned NUM_IRQ = 8;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned CODE_LSB = 9;
  localparam int unsigned WCRC_BIT = 2;

  localparam logic [DW-1:0] STICKY_MASK = 32'hC300_782F;
  localparam logic [DW-1:0] LEVEL_MASK  = 32'h3C00_01C0;
  localparam logic [DW-1:0] ERR_MASK    = 32'h0000_002F;
  localparam logic [DW-1:0] EN_WMASK    = 32'h0007_F01F;

  // lvl_i index -> status bit
  localparam int LVL_POS [NUM_LVL] = '{6, 7, 8, 26, 27, 28, 29};
  // interrupt source pairs
  localparam int IRQ_EN_IDX [NUM_IRQ] = '{0, 1, 2, 3, 4, 13, 14, 15};
  localparam int IRQ_ST_IDX [NUM_IRQ] = '{11, 12, 13, 6, 7, 14, 30, 31};

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;
endpackage

// File: rtl/sdh_stat_sticky.sv
module sdh_stat_sticky #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0]  MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flop
      logic bit_q;
      // set has priority over clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= set_i[i] | (bit_q & ~clr_i[i]);
      end
      assign q_o[i] = bit_q;
    end else begin : g_none
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sdh_stat_level.sv
module sdh_stat_level
  import sdh_stat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] lvl_i,
  output logic [DW-1:0]      q_o
);
  logic [DW-1:0] placed;

  always_comb begin
    placed = '0;
    for (int k = 0; k < NUM_LVL; k++) placed[LVL_POS[k]] = lvl_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= placed;
  end
endmodule

// File: rtl/sdh_irq_gen.sv
module sdh_irq_gen
  import sdh_stat_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] en_i,
  output logic          irq_o
);
  logic [NUM_IRQ-1:0] hit;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_src
    assign hit[k] = status_i[IRQ_ST_IDX[k]] & en_i[IRQ_EN_IDX[k]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |hit;
  end
endmodule

// File: rtl/sdh_stat_irq.sv
module sdh_stat_irq
  import sdh_stat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DW-1:0]      evt_i,
  input  logic [NUM_LVL-1:0] lvl_i,
  input  logic [CODE_W-1:0]  wcrc_code_i,
  input  logic               bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               irq_o
);
  logic [DW-1:0]     clr_w;
  logic [DW-1:0]     sticky_w;
  logic [DW-1:0]     level_w;
  logic [DW-1:0]     status_w;
  logic [DW-1:0]     en_q;
  logic [CODE_W-1:0] code_q;
  reg_sel_e          sel;

  assign sel   = reg_sel_e'(bus_addr_i);
  assign clr_w = (bus_we_i && sel == SEL_STATUS) ? bus_wdata_i : '0;

  sdh_stat_sticky #(.W(DW), .MASK(STICKY_MASK)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (clr_w),
    .q_o   (sticky_w)
  );

  sdh_stat_level u_level (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_i),
    .q_o   (level_w)
  );

  // write-CRC code follows the life of its error flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                code_q <= '0;
    else if (evt_i[WCRC_BIT])   code_q <= wcrc_code_i;
    else if (clr_w[WCRC_BIT])   code_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              en_q <= '0;
    else if (bus_we_i && sel == SEL_ENABLE)   en_q <= bus_wdata_i & EN_WMASK;
  end

  always_comb begin
    status_w = sticky_w | level_w;
    status_w[CODE_LSB +: CODE_W] = code_q;
  end

  assign bus_rdata_o = (sel == SEL_STATUS) ? status_w : en_q;

  sdh_irq_gen u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_w),
    .en_i    (en_q),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/sdh_stat_irq_chk.sv
module sdh_stat_irq_chk
  import sdh_stat_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DW-1:0]      evt_i,
  input logic [NUM_LVL-1:0] lvl_i,
  input logic               bus_addr_i,
  input logic               bus_we_i,
  input logic [DW-1:0]      bus_wdata_i,
  input logic [DW-1:0]      status_i,
  input logic [DW-1:0]      en_i,
  input logic               irq_o
);
  logic any_src;
  assign any_src = (status_i[11] & en_i[0]) | (status_i[12] & en_i[1]) |
                   (status_i[13] & en_i[2]) | (status_i[6]  & en_i[3]) |
                   (status_i[7]  & en_i[4]) | (status_i[14] & en_i[13]) |
                   (status_i[30] & en_i[14]) | (status_i[31] & en_i[15]);

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((status_i & $past(evt_i & STICKY_MASK)) == $past(evt_i & STICKY_MASK)));

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !bus_addr_i) |=>
      ((status_i & $past(bus_wdata_i & ~evt_i & STICKY_MASK)) == '0));

  assert_level_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (status_i[6] == $past(lvl_i[0]) && status_i[29] == $past(lvl_i[6])));

  assert_code_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i[2] |-> (status_i[10:9] == 2'b00));

  assert_irq_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (irq_o == $past(any_src)));
endmodule

bind sdh_stat_irq sdh_stat_irq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .lvl_i      (lvl_i),
  .bus_addr_i (bus_addr_i),
  .bus_we_i   (bus_we_i),
  .bus_wdata_i(bus_wdata_i),
  .status_i   (status_w),
  .en_i       (en_q),
  .irq_o      (irq_o)
);

// File: tb/sdh_stat_irq_tb.sv
module sdh_stat_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic [6:0]  lvl = '0;
  logic [1:0]  code = '0;
  logic        addr = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdh_stat_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .lvl_i(lvl), .wcrc_code_i(code),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  localparam logic [31:0] M_STICKY = 32'hC300_782F;
  localparam logic [31:0] M_ENW    = 32'h0007_F01F;
  logic [31:0] m_st, m_en, t_st, t_clr;
  bit          m_irq, t_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_irq = 1'b0;
    end else begin
      t_clr = (we && !addr) ? wdata : '0;
      t_irq = (m_en[0] && m_st[11]) || (m_en[1] && m_st[12]) || (m_en[2] && m_st[13]) ||
              (m_en[3] && m_st[6])  || (m_en[4] && m_st[7])  || (m_en[13] && m_st[14]) ||
              (m_en[14] && m_st[30]) || (m_en[15] && m_st[31]);
      t_st = ((m_st & ~t_clr) | evt) & M_STICKY;
      t_st[6] = lvl[0]; t_st[7] = lvl[1]; t_st[8] = lvl[2];
      t_st[26] = lvl[3]; t_st[27] = lvl[4]; t_st[28] = lvl[5]; t_st[29] = lvl[6];
      if (evt[2])        t_st[10:9] = code;
      else if (t_clr[2]) t_st[10:9] = 2'b00;
      else               t_st[10:9] = m_st[10:9];
      if (we && addr) m_en = wdata & M_ENW;
      m_st = t_st;
      m_irq = t_irq;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    check({cur_req, " rdata"}, rdata, addr ? m_en : m_st);
    check({cur_req, " irq"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  // at negedge: compare, then drive next cycle's inputs
  task automatic step(input logic [31:0] e, input logic [6:0] l, input logic [1:0] c,
                      input logic a, input logic w, input logic [31:0] d);
    @(negedge clk);
    compare();
    evt = e; lvl = l; code = c; addr = a; we = w; wdata = d;
  endtask

  task automatic idle(input logic a);
    step('0, lvl, '0, a, 1'b0, '0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(1'b0); idle(1'b1); idle(1'b0);

    // R2 each bit strobed alone
    cur_req = "R2";
    for (int i = 0; i < 32; i++) begin
      step(32'h1 << i, '0, 2'd0, 1'b0, 1'b0, '0);
      idle(1'b0);
    end
    idle(1'b0);

    // R3 partial clears, zero write
    cur_req = "R3";
    step('0, '0, '0, 1'b0, 1'b1, 32'h0000_3005);
    idle(1'b0);
    step('0, '0, '0, 1'b0, 1'b1, 32'h0);
    idle(1'b0);
    step('0, '0, '0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    idle(1'b0);

    // R4 set and clear collide
    cur_req = "R4";
    step(32'h0000_2000, '0, '0, 1'b0, 1'b1, 32'h0000_2000);
    idle(1'b0);
    step(32'h8000_0001, '0, '0, 1'b0, 1'b1, 32'h8000_2001);
    idle(1'b0);

    // R5 live levels, writes ignored
    cur_req = "R5";
    step('0, 7'b1010101, '0, 1'b0, 1'b0, '0);
    step('0, 7'b0101010, '0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    step('0, 7'b1111111, '0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    step('0, 7'b1111111, '0, 1'b0, 1'b0, '0);
    step('0, 7'b0000000, '0, 1'b0, 1'b0, '0);
    idle(1'b0);

    // R6 write-CRC code field
    cur_req = "R6";
    step(32'h4, '0, 2'd2, 1'b0, 1'b0, '0);
    idle(1'b0);
    step(32'h4, '0, 2'd1, 1'b0, 1'b0, '0);
    idle(1'b0);
    step('0, '0, 2'd3, 1'b0, 1'b1, 32'h4);
    idle(1'b0);
    step(32'h4, '0, 2'd3, 1'b0, 1'b1, 32'h4);
    idle(1'b0);
    step('0, '0, '0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    idle(1'b0);

    // R7 enable write mask
    cur_req = "R7";
    step('0, '0, '0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    idle(1'b1);
    step('0, '0, '0, 1'b1, 1'b1, 32'h0000_0000);
    idle(1'b1);

    // R8 each source pair alone
    cur_req = "R8";
    for (int k = 0; k < 8; k++) begin
      logic [31:0] en_bit, st_bit;
      logic [6:0]  lv;
      int ei, si;
      case (k)
        0: begin ei = 0;  si = 11; end
        1: begin ei = 1;  si = 12; end
        2: begin ei = 2;  si = 13; end
        3: begin ei = 3;  si = 6;  end
        4: begin ei = 4;  si = 7;  end
        5: begin ei = 13; si = 14; end
        6: begin ei = 14; si = 30; end
        default: begin ei = 15; si = 31; end
      endcase
      en_bit = 32'h1 << ei;
      st_bit = 32'h1 << si;
      lv = (si == 6) ? 7'b0000001 : (si == 7) ? 7'b0000010 : 7'b0;
      step('0, '0, '0, 1'b1, 1'b1, en_bit);
      step((si == 6 || si == 7) ? 32'h0 : st_bit, lv, '0, 1'b0, 1'b0, '0);
      step('0, lv, '0, 1'b0, 1'b0, '0);
      step('0, lv, '0, 1'b0, 1'b0, '0);
      step('0, '0, '0, 1'b0, 1'b1, 32'hFFFF_FFFF);
      idle(1'b0); idle(1'b0);
    end

    // R9 errors alone with all enables
    cur_req = "R9";
    step('0, '0, '0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    step(32'h0000_002F, '0, 2'd2, 1'b0, 1'b0, '0);
    idle(1'b0); idle(1'b0); idle(1'b0);
    step('0, '0, '0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    idle(1'b0);

    // R10 address toggling with mixed traffic
    cur_req = "R10";
    step(32'h0300_0800, 7'b0011000, '0, 1'b1, 1'b0, '0);
    idle(1'b0);
    idle(1'b1);
    step(32'h4000_1000, 7'b0000100, '0, 1'b0, 1'b0, '0);
    idle(1'b1);
    idle(1'b0);
    step('0, '0, '0, 1'b1, 1'b1, 32'h0000_F000);
    idle(1'b0);
    idle(1'b1);
    idle(1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule